// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting timer channel driven from a synchronous system clock. Software writes a control byte that picks one of six output waveform modes, binary or decimal (BCD) counting, and the byte order used to load the initial count. It then writes the count bytes on the same byte-wide port. Each one-cycle pulse on `tick` stands for one rising edge of the count clock. On that edge the channel loads, decrements or reloads its counter and updates `outLine` according to the mode. The `gate` input either pauses counting (level-sensitive modes) or starts and restarts it on a rising level seen at a tick (edge-triggered modes).

A control byte whose access field is zero does not reprogram the channel. It freezes a snapshot of the count on `readCount` until the next control byte or count byte arrives. An initial count of zero is the longest count: 65536 ticks in binary and 10000 ticks in BCD.

Top module: `pit_channel`

## Requirements
- R1: A control byte with access field bits 5..4 non-zero sets the mode from bits 3..1, BCD counting from bit 0 (1 = BCD), and the access format. Mode codes 6 and 7 act as modes 2 and 3, and bits 7..6 are ignored. On the next cycle `outLine` is low for mode 0 and high for every other mode. No counting happens until a complete count has been written.
- R2: The access format is set by bits 5..4. Code 01 loads the low byte and clears the high byte. Code 10 loads the high byte and clears the low byte. Code 11 takes two writes, low byte first and then high byte.
- R3: A control byte with access field 00 copies the current count to `readCount` and holds it there. Mode, format and output are left unchanged. The hold ends at the next count byte or at a control byte with a non-zero access field.
- R4: Binary counting decrements modulo 65536, so 0000h is followed by FFFFh.
- R5: BCD counting decrements digit by digit with borrow: 0100 is followed by 0099, and 0000 is followed by 9999. In mode 2 a zero count gives a period of 10000 ticks.
- R6: Mode 0. The first tick after a count is complete loads it. `outLine` rises on the tick at which the count goes from 1 to 0 (the N+1th tick after the write) and stays high. Writing a complete count drives it low again on the next cycle.
- R7: Mode 1. A tick that sees `gate` high after seeing it low at the previous tick loads the count and drives `outLine` low. `outLine` returns high N ticks later. A new trigger while the output is low restarts the N-tick low time.
- R8: Mode 2. After loading, `outLine` is low for exactly one tick out of every N ticks. It goes low when the count steps from 2 to 1, and the count then reloads on the next tick with `outLine` high.
- R9: Mode 3. The output is a square wave with period N. For even N it is high N/2 ticks and low N/2 ticks. For odd N it is high (N+1)/2 ticks and low (N-1)/2 ticks.
- R10: Mode 4. The tick at which the count steps from 1 to 0 drives `outLine` low for exactly one tick. The pulse happens only once per written count.
- R11: Mode 5. A gate trigger (as in R7) loads the count with `outLine` high. N ticks after the trigger, `outLine` pulses low for exactly one tick. Retriggering is allowed.
- R12: In modes 0, 2, 3 and 4, ticks taken while `gate` is low do not change the count. In modes 0, 2 and 3 they do not change `outLine` either. The load tick still takes effect.
- R13: After reset, `outLine` is low, `readCount` is 0, and the channel is in mode 0, binary, with format 11.
- R14: `outLine` changes only in the cycle after a `tick`, `ctrlWr` or `cntWr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWr | input | 1 | Control byte write strobe |
| cntWr | input | 1 | Count byte write strobe |
| dataIn | input | 8 | Byte written by either strobe |
| tick | input | 1 | One-cycle count clock edge |
| gate | input | 1 | Gate level, sampled at ticks |
| outLine | output | 1 | Timer output waveform |
| readCount | output | 16 | Live count, or the held snapshot |

## Verification
A wrong count register or a broken BCD borrow shows up on `readCount` at the first tick that passes the faulty value. It also moves the `outLine` edge by at least one tick, which breaks the scoreboard's tick-by-tick waveform. A stale phase flag in the square-wave or one-shot logic shows up within one period as a half-period one tick too long or too short. A stuck gate-edge memory shows up at the next trigger as a missing or spurious low output.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } accT;

  localparam logic [2:0] MODE_TC     = 3'd0;
  localparam logic [2:0] MODE_ONESHOT = 3'd1;
  localparam logic [2:0] MODE_RATE   = 3'd2;
  localparam logic [2:0] MODE_SQUARE = 3'd3;
  localparam logic [2:0] MODE_SWSTB  = 3'd4;
  localparam logic [2:0] MODE_HWSTB  = 3'd5;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic zeroLo;
    logic zeroHi;
    logic reload;
    logic reloadEven;
    logic dec1;
    logic dec2;
    logic latch;
    logic unlatch;
  } dpCmdT;

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmdT                 cmd,
  input  logic                  bcdMode,
  input  logic [BYTE_W-1:0]     dataIn,
  output logic [2*BYTE_W-1:0]   readCount,
  output logic                  cntIsOne,
  output logic                  cntIsTwo,
  output logic                  initOdd,
  output logic                  isLatched
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int DIGITS = CNT_W / 4;

  logic [CNT_W-1:0] loadVal, countQ, latchVal, decA, decB;
  logic             latchedQ;

  function automatic logic [CNT_W-1:0] decOne(input logic [CNT_W-1:0] v,
                                              input logic useBcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!useBcd) begin
      r = v - CNT_W'(1);
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (v[4*d +: 4] == 4'd0) begin
            r[4*d +: 4] = 4'd9;
          end else begin
            r[4*d +: 4] = v[4*d +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction

  assign decA = decOne(countQ, bcdMode);
  assign decB = decOne(decA, bcdMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadVal  <= '0;
      countQ   <= '0;
      latchVal <= '0;
      latchedQ <= 1'b0;
    end else begin
      if (cmd.loadLo) loadVal[BYTE_W-1:0]     <= dataIn;
      if (cmd.zeroLo) loadVal[BYTE_W-1:0]     <= '0;
      if (cmd.loadHi) loadVal[CNT_W-1:BYTE_W] <= dataIn;
      if (cmd.zeroHi) loadVal[CNT_W-1:BYTE_W] <= '0;

      if (cmd.reload)          countQ <= loadVal;
      else if (cmd.reloadEven) countQ <= {loadVal[CNT_W-1:1], 1'b0};
      else if (cmd.dec1)       countQ <= decA;
      else if (cmd.dec2)       countQ <= decB;

      if (cmd.latch) begin
        latchVal <= countQ;
        latchedQ <= 1'b1;
      end else if (cmd.unlatch) begin
        latchedQ <= 1'b0;
      end
    end
  end

  assign readCount = latchedQ ? latchVal : countQ;
  assign cntIsOne  = (countQ == CNT_W'(1));
  assign cntIsTwo  = (countQ == CNT_W'(2));
  assign initOdd   = loadVal[0];
  assign isLatched = latchedQ;

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              cntWr,
  input  logic              tick,
  input  logic              gate,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              cntIsOne,
  input  logic              cntIsTwo,
  input  logic              initOdd,
  output dpCmdT             cmd,
  output logic              bcdMode,
  output logic              outLine,
  output logic [2:0]        modeEff,
  output logic              loadPend
);
  // Control byte field positions
  localparam int BCD_BIT  = 0;
  localparam int MODE_LSB = 1;
  localparam int ACC_LSB  = 4;

  logic [2:0] modeQ, modeN, codeIn;
  accT        accQ, accN;
  logic bcdQ, bcdN, waitHiQ, waitHiN, armedQ, armedN, pendQ, pendN;
  logic runQ, runN, firedQ, firedN, extraQ, extraN, outQ, outN;
  logic gPrevQ, gPrevN, trig, levelMode;

  assign codeIn    = dataIn[MODE_LSB +: 3];
  assign trig      = gate & ~gPrevQ;
  assign levelMode = (modeQ != MODE_ONESHOT) && (modeQ != MODE_HWSTB);

  always_comb begin
    modeN = modeQ;  accN = accQ;   bcdN = bcdQ;   waitHiN = waitHiQ;
    armedN = armedQ; pendN = pendQ; runN = runQ;  firedN = firedQ;
    extraN = extraQ; outN = outQ;  gPrevN = gPrevQ;
    cmd = '0;
    if (ctrlWr) begin
      if (dataIn[ACC_LSB +: 2] == ACC_LATCH) begin
        cmd.latch = 1'b1;
      end else begin
        modeN   = {codeIn[2] & ~codeIn[1], codeIn[1:0]};
        bcdN    = dataIn[BCD_BIT];
        accN    = accT'(dataIn[ACC_LSB +: 2]);
        waitHiN = 1'b0;  armedN = 1'b0; pendN = 1'b0; runN = 1'b0;
        firedN  = 1'b0;  extraN = 1'b0;
        outN    = (modeN != MODE_TC);
        cmd.unlatch = 1'b1;
      end
    end else begin
      if (tick) begin
        gPrevN = gate;
        case (modeQ)
          MODE_TC, MODE_SWSTB: begin
            if (modeQ == MODE_SWSTB) outN = 1'b1;
            if (pendQ) begin
              cmd.reload = 1'b1; pendN = 1'b0; runN = 1'b1;
            end else if (runQ && gate) begin
              cmd.dec1 = 1'b1;
              if (cntIsOne) begin
                if (modeQ == MODE_TC) outN = 1'b1;
                else if (!firedQ) begin
                  outN = 1'b0; firedN = 1'b1;
                end
              end
            end
          end
          MODE_RATE: begin
            if (pendQ) begin
              cmd.reload = 1'b1; outN = 1'b1; pendN = 1'b0; runN = 1'b1;
            end else if (runQ && gate) begin
              if (cntIsOne) begin
                cmd.reload = 1'b1; outN = 1'b1;
              end else begin
                cmd.dec1 = 1'b1;
                if (cntIsTwo) outN = 1'b0;
              end
            end
          end
          MODE_SQUARE: begin
            if (pendQ) begin
              cmd.reloadEven = 1'b1; outN = 1'b1; extraN = 1'b0;
              pendN = 1'b0; runN = 1'b1;
            end else if (runQ && gate) begin
              if (cntIsTwo) begin
                if (outQ && initOdd && !extraQ) begin
                  extraN = 1'b1;
                end else begin
                  cmd.reloadEven = 1'b1;
                  outN = ~outQ;
                  if (!outQ) extraN = 1'b0;
                end
              end else begin
                cmd.dec2 = 1'b1;
              end
            end
          end
          MODE_ONESHOT, MODE_HWSTB: begin
            if (modeQ == MODE_HWSTB) outN = 1'b1;
            if (armedQ && trig) begin
              cmd.reload = 1'b1; runN = 1'b1;
              outN = (modeQ == MODE_HWSTB);
            end else if (runQ) begin
              cmd.dec1 = 1'b1;
              if (cntIsOne) begin
                runN = 1'b0;
                outN = (modeQ == MODE_ONESHOT);
              end
            end
          end
          default: ;
        endcase
      end
      if (cntWr) begin
        cmd.unlatch = 1'b1;
        case (accQ)
          ACC_LO: begin
            cmd.loadLo = 1'b1; cmd.zeroHi = 1'b1; armedN = 1'b1;
          end
          ACC_HI: begin
            cmd.loadHi = 1'b1; cmd.zeroLo = 1'b1; armedN = 1'b1;
          end
          ACC_LOHI: begin
            if (!waitHiQ) begin
              cmd.loadLo = 1'b1; waitHiN = 1'b1;
            end else begin
              cmd.loadHi = 1'b1; waitHiN = 1'b0; armedN = 1'b1;
            end
          end
          default: ;
        endcase
        if (armedN && !(accQ == ACC_LOHI && !waitHiQ)) begin
          firedN = 1'b0;
          if (levelMode) pendN = 1'b1;
          if (modeQ == MODE_TC) outN = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_TC; accQ <= ACC_LOHI; bcdQ <= 1'b0; waitHiQ <= 1'b0;
      armedQ <= 1'b0; pendQ <= 1'b0; runQ <= 1'b0; firedQ <= 1'b0;
      extraQ <= 1'b0; outQ <= 1'b0; gPrevQ <= 1'b0;
    end else begin
      modeQ <= modeN; accQ <= accN; bcdQ <= bcdN; waitHiQ <= waitHiN;
      armedQ <= armedN; pendQ <= pendN; runQ <= runN; firedQ <= firedN;
      extraQ <= extraN; outQ <= outN; gPrevQ <= gPrevN;
    end
  end

  assign outLine  = outQ;
  assign bcdMode  = bcdQ;
  assign modeEff  = modeQ;
  assign loadPend = pendQ;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWr,
  input  logic                cntWr,
  input  logic [BYTE_W-1:0]   dataIn,
  input  logic                tick,
  input  logic                gate,
  output logic                outLine,
  output logic [2*BYTE_W-1:0] readCount
);
  dpCmdT      cmd;
  logic       bcdMode, cntIsOne, cntIsTwo, initOdd, isLatched, loadPend;
  logic [2:0] modeEff;

  pit_control #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .cntWr(cntWr), .tick(tick),
    .gate(gate), .dataIn(dataIn), .cntIsOne(cntIsOne), .cntIsTwo(cntIsTwo),
    .initOdd(initOdd), .cmd(cmd), .bcdMode(bcdMode), .outLine(outLine),
    .modeEff(modeEff), .loadPend(loadPend)
  );

  pit_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .bcdMode(bcdMode), .dataIn(dataIn),
    .readCount(readCount), .cntIsOne(cntIsOne), .cntIsTwo(cntIsTwo),
    .initOdd(initOdd), .isLatched(isLatched)
  );

endmodule

// File: rtl/pit_channel_checker.sv
module pit_channel_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                ctrlWr,
  input logic                cntWr,
  input logic                tick,
  input logic                gate,
  input logic [BYTE_W-1:0]   dataIn,
  input logic                outLine,
  input logic [2*BYTE_W-1:0] readCount,
  input logic [2:0]          modeEff,
  input logic                loadPend,
  input logic                isLatched
);

  assert_ctrl_init_level_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && dataIn[5:4] != 2'b00) |=> (outLine == ($past(dataIn[3:1]) != 3'd0)));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isLatched && !ctrlWr && !cntWr) |=> $stable(readCount));

  assert_tc_stays_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeEff == 3'd0 && outLine && !ctrlWr && !cntWr) |=> outLine);

  assert_strobe_one_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((modeEff == 3'd4 || modeEff == 3'd5) && !outLine && tick && !ctrlWr) |=> outLine);

  assert_gate_freeze_R12: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !gate && !loadPend && !ctrlWr && !cntWr &&
     (modeEff == 3'd0 || modeEff == 3'd2 || modeEff == 3'd3))
    |=> ($stable(outLine) && $stable(readCount)));

  assert_out_quiet_R14: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !ctrlWr && !cntWr) |=> $stable(outLine));

endmodule

bind pit_channel pit_channel_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .cntWr(cntWr), .tick(tick),
  .gate(gate), .dataIn(dataIn), .outLine(outLine), .readCount(readCount),
  .modeEff(modeEff), .loadPend(loadPend), .isLatched(isLatched)
);

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, ctrlWr = 1'b0, cntWr = 1'b0, tick = 1'b0, gate = 1'b0;
  logic [7:0]  dataIn = '0;
  logic        outLine;
  logic [15:0] readCount;

  int checkCount = 0, failCount = 0;
  bit done = 1'b0;

  typedef struct { bit v; string tag; } sbItemT;
  sbItemT sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .cntWr(cntWr), .dataIn(dataIn),
    .tick(tick), .gate(gate), .outLine(outLine), .readCount(readCount)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: compare the output after every tick against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (tick) begin
        #2;
        checkCount++;
        if (sbQ.size() == 0) begin
          failCount++;
          $display("FAIL scoreboard: actual %0b expected nothing queued", outLine);
        end else begin
          sbItemT it;
          it = sbQ.pop_front();
          if (outLine !== it.v) begin
            failCount++;
            $display("FAIL %s: actual outLine %0b expected %0b", it.tag, outLine, it.v);
          end
        end
      end
    end
  end

  task automatic wrCtrl(input logic [7:0] b);
    @(negedge clk); dataIn = b; ctrlWr = 1'b1;
    @(negedge clk); ctrlWr = 1'b0;
  endtask

  task automatic wrCnt(input logic [7:0] b);
    @(negedge clk); dataIn = b; cntWr = 1'b1;
    @(negedge clk); cntWr = 1'b0;
  endtask

  task automatic step(input bit v, input string tag);
    sbQ.push_back('{v, tag});
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run(input bit v, input int n, input string tag);
    for (int i = 0; i < n; i++) step(v, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failCount++;
    $display("FAIL watchdog: actual running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(outLine, 0, "R13 reset out");
    chk(readCount, 0, "R13 reset count");
    rstN = 1'b1;

    // R6 mode 0 binary, low-byte format, N=5
    wrCtrl(8'h10);
    chk(outLine, 0, "R1 mode0 init low");
    wrCnt(8'h05);
    gate = 1'b1;
    step(0, "R6 load tick");
    chk(readCount, 5, "R2 low-byte load");
    run(0, 4, "R6 counting");
    run(1, 3, "R6 terminal high");
    // R12 gate low suspends; rewrite forces low
    wrCnt(8'h03);
    chk(outLine, 0, "R6 rewrite low");
    gate = 1'b0;
    step(0, "R12 load with gate low");
    run(0, 4, "R12 gate low");
    chk(readCount, 3, "R12 count frozen");
    gate = 1'b1;
    run(0, 2, "R12 resume");
    step(1, "R12 terminal after resume");

    // R8 mode 2, bits 7..6 set (ignored), N=4
    wrCtrl(8'hD4);
    chk(outLine, 1, "R1 mode2 init high");
    wrCnt(8'h04);
    for (int p = 0; p < 2; p++) begin
      if (p == 0) step(1, "R8 load"); else step(1, "R8 reload");
      run(1, 2, "R8 high");
      step(0, "R8 one-tick low");
    end
    step(1, "R8 reload high");

    // R9 mode 3 odd N=5 using alias code 7
    wrCtrl(8'h1E);
    wrCnt(8'h05);
    for (int p = 0; p < 2; p++) begin
      run(1, 3, "R9 odd high (N+1)/2");
      run(0, 2, "R9 odd low (N-1)/2");
    end
    step(1, "R9 odd next high");
    // R9 even N=4
    wrCtrl(8'h16);
    wrCnt(8'h04);
    for (int p = 0; p < 2; p++) begin
      run(1, 2, "R9 even high");
      run(0, 2, "R9 even low");
    end

    // R10 mode 4, N=3
    wrCtrl(8'h18);
    wrCnt(8'h03);
    run(1, 3, "R10 before strobe");
    step(0, "R10 strobe");
    run(1, 4, "R10 after strobe");

    // R7 mode 1, N=3
    gate = 1'b0;
    wrCtrl(8'h12);
    wrCnt(8'h03);
    run(1, 2, "R7 waiting for trigger");
    gate = 1'b1;
    run(0, 3, "R7 low width");
    run(1, 2, "R7 returns high");
    gate = 1'b0; step(1, "R7 idle");
    gate = 1'b1; run(0, 2, "R7 first trigger");
    gate = 1'b0; step(0, "R7 gate level ignored");
    gate = 1'b1; run(0, 3, "R7 retrigger");
    step(1, "R7 retrigger end");

    // R11 mode 5, N=2
    gate = 1'b0;
    wrCtrl(8'h1A);
    wrCnt(8'h02);
    step(1, "R11 idle");
    gate = 1'b1;
    run(1, 2, "R11 before strobe");
    step(0, "R11 strobe");
    run(1, 2, "R11 after strobe");

    // R5 BCD, two-byte format, wrap 0000 -> 9999
    wrCtrl(8'h31);
    wrCnt(8'h01); wrCnt(8'h00);
    step(0, "R5 load");
    chk(readCount, 16'h0001, "R2 two-byte load");
    step(1, "R6 reaches zero");
    step(1, "R6 stays high");
    chk(readCount, 16'h9999, "R5 BCD wrap");
    // R5 borrow, R3 latch
    wrCtrl(8'h31);
    wrCnt(8'h00); wrCnt(8'h01);
    step(0, "R5 load 0100");
    step(0, "R5 borrow");
    chk(readCount, 16'h0099, "R5 borrow value");
    wrCtrl(8'h0E);
    chk(outLine, 0, "R3 latch keeps output");
    run(0, 2, "R3 mode unchanged");
    chk(readCount, 16'h0099, "R3 held value");
    wrCtrl(8'h31);
    chk(readCount, 16'h0097, "R3 released live count");

    // R4 binary wrap, R2 ordering
    wrCtrl(8'h30);
    wrCnt(8'h34); wrCnt(8'h12);
    step(0, "R2 load");
    chk(readCount, 16'h1234, "R2 low then high");
    wrCnt(8'h00); wrCnt(8'h00);
    step(0, "R4 load zero");
    step(0, "R4 wrap");
    chk(readCount, 16'hFFFF, "R4 binary wrap");
    wrCtrl(8'h20);
    wrCnt(8'h01);
    step(0, "R2 high-only load");
    chk(readCount, 16'h0100, "R2 high-only value");

    // R5 BCD zero count in mode 2: 10000-tick period
    wrCtrl(8'h35);
    wrCnt(8'h00); wrCnt(8'h00);
    run(1, 9999, "R5 max period high");
    step(0, "R5 max period low");
    step(1, "R5 max period reload");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule